// File: doc/BRIEF.md
# One-wire ROM search sequencer

This engine walks a one-wire bus and lists the 64-bit identifier of every device attached to it, with no processor work per bit. It sits between a controller that pulses `start` and the byte-exchange and reset front end of a bus master. It asks that front end for bus resets and single-byte exchanges, and it holds a mode line that switches the front end into its search-accelerator exchange.

Each pass works the same way. The engine issues a reset and checks for a presence pulse, then sends the search command byte and raises the accelerator line. It then exchanges sixteen bytes, and each byte carries one nibble of the chosen path. Each reply carries four identifier bits and four discrepancy flags. The engine drops the accelerator line, resets the bus, and then judges the result. A good identifier is strobed out, and the next path is taken from the deepest discrepancy not yet explored. The search ends when no discrepancy remains, when no device answers the reset, when the pass limit is reached, or when an exchange times out.

Top module: `onew_search`

## Requirements
- R1: Every pass begins with exactly one `rst_req` pulse, and no reset and exchange request are ever raised in the same cycle. If `presence` is low with `rst_done` at the start of a pass, `done` pulses with `aborted` low and no further request follows.
- R2: After presence, the first exchange of a pass sends `CMD_BYTE` (default 8'hF0) with `acc_en` low. `acc_en` then rises, and 16 exchanges follow, carrying path nibbles 0 to 15 with the least significant nibble first.
- R3: In each path byte, path bit j of the nibble (j = 0..3) is sent on `xfer_tx` bit 2j+1, and the even bits are zero.
- R4: In each reply byte, `xfer_rx` bit 2j+1 is identifier bit 4n+j and bit 2j is discrepancy flag 4n+j, where n is the nibble index.
- R5: After the 16th exchange, `acc_en` falls and a second reset is requested. `acc_en` is never high while a reset is requested.
- R6: If identifier bit 63 and discrepancy bit 63 are both 1, nothing is reported and the pass is repeated with the same path.
- R7: The next path is formed in three steps. First, clear each discrepancy bit where the current path is 1. Then take the most significant remaining bit m. The new path keeps the path bits below m, sets bit m and clears every bit above m. The first pass uses an all-zero path.
- R8: Each accepted identifier appears on `rom_id` with a one-cycle `rom_valid` pulse, and `dev_count` is one higher in that same cycle.
- R9: When no discrepancy remains after masking, `done` pulses in the same cycle as that pass's `rom_valid`, with `aborted` low.
- R10: If `MAX_PASS` (default 100) passes have run without completing, the search ends with `done` and `aborted` high, and no further reset is requested.
- R11: An `xfer_timeout` in place of `xfer_done` on any exchange ends the search at once: `done` and `aborted` go high, `acc_en` goes low, and no request follows.
- R12: After reset the engine is idle, with every output low and `dev_count` zero. `start` clears the count and is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an enumeration (ignored while busy) |
| busy | output | 1 | Enumeration in progress |
| done | output | 1 | One-cycle pulse at the end of an enumeration |
| aborted | output | 1 | Set with done when the end came from timeout or pass limit |
| rom_id | output | 64 | Last identifier found |
| rom_valid | output | 1 | One-cycle strobe for rom_id |
| dev_count | output | CNT_W | Identifiers reported since start |
| rst_req | output | 1 | Pulse: request a bus reset |
| rst_done | input | 1 | Pulse: bus reset finished |
| presence | input | 1 | Presence seen, valid with rst_done |
| acc_en | output | 1 | Search-accelerator exchange mode |
| xfer_req | output | 1 | Pulse: exchange the byte on xfer_tx |
| xfer_tx | output | 8 | Byte to send |
| xfer_done | input | 1 | Pulse: exchange finished, xfer_rx valid |
| xfer_timeout | input | 1 | Pulse: exchange failed |
| xfer_rx | input | 8 | Byte received |

## Verification
The final pass of a normal search reports its identifier and signals the end of the search in one and the same cycle, so `rom_valid` and `done` must coincide. The bench provokes this with random and directed device sets, including sets whose identifiers differ only in bit 0 or bit 62. It judges each final report by requiring `done` high with `aborted` low exactly when its own path model finds no discrepancy left, and `done` low on every earlier report. Bus errors injected into a single pass and into every pass are judged by the pass and reset counts seen on the bus.

// File: rtl/onew_search.sv
module onew_search #(
  parameter int          ID_W     = 64,
  parameter int          MAX_PASS = 100,
  parameter int          CNT_W    = 8,
  parameter logic [7:0]  CMD_BYTE = 8'hF0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic             aborted,
  output logic [ID_W-1:0]  rom_id,
  output logic             rom_valid,
  output logic [CNT_W-1:0] dev_count,
  output logic             rst_req,
  input  logic             rst_done,
  input  logic             presence,
  output logic             acc_en,
  output logic             xfer_req,
  output logic [7:0]       xfer_tx,
  input  logic             xfer_done,
  input  logic             xfer_timeout,
  input  logic [7:0]       xfer_rx
);
  localparam int NIBS = ID_W / 4;
  localparam int NW   = $clog2(NIBS);
  localparam int PW   = $clog2(MAX_PASS + 1);

  typedef enum logic [2:0] {S_IDLE, S_PASS, S_RST1, S_CMD, S_EXCH, S_RST2, S_EVAL} st_t;

  st_t             st;
  logic [ID_W-1:0] path, idw, dsc;
  logic [NW-1:0]   nib;
  logic [PW-1:0]   pass_cnt;

  function automatic logic [7:0] enc(input logic [3:0] p);
    return {p[3], 1'b0, p[2], 1'b0, p[1], 1'b0, p[0], 1'b0};
  endfunction

  function automatic logic [ID_W-1:0] smear(input logic [ID_W-1:0] v);
    logic [ID_W-1:0] s;
    s = v;
    for (int k = 1; k < ID_W; k = k * 2) s = s | (s >> k);
    return s;
  endfunction

  wire [NW-1:0]   nib_nx  = nib + 1'b1;
  wire [3:0]      rx_id   = {xfer_rx[7], xfer_rx[5], xfer_rx[3], xfer_rx[1]};
  wire [3:0]      rx_ds   = {xfer_rx[6], xfer_rx[4], xfer_rx[2], xfer_rx[0]};
  wire [ID_W-1:0] d_left  = dsc & ~path;
  wire [ID_W-1:0] d_smr   = smear(d_left);
  wire [ID_W-1:0] nxt     = (path & (d_smr >> 1)) | (d_smr & ~(d_smr >> 1));
  wire            bus_err = idw[ID_W-1] & dsc[ID_W-1];

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      path      <= '0;
      idw       <= '0;
      dsc       <= '0;
      nib       <= '0;
      pass_cnt  <= '0;
      done      <= 1'b0;
      aborted   <= 1'b0;
      rom_id    <= '0;
      rom_valid <= 1'b0;
      dev_count <= '0;
      rst_req   <= 1'b0;
      acc_en    <= 1'b0;
      xfer_req  <= 1'b0;
      xfer_tx   <= '0;
    end else begin
      rst_req   <= 1'b0;
      xfer_req  <= 1'b0;
      rom_valid <= 1'b0;
      done      <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          path      <= '0;
          pass_cnt  <= '0;
          dev_count <= '0;
          aborted   <= 1'b0;
          st        <= S_PASS;
        end
        S_PASS: begin
          if (pass_cnt == PW'(MAX_PASS)) begin
            done    <= 1'b1;
            aborted <= 1'b1;
            st      <= S_IDLE;
          end else begin
            pass_cnt <= pass_cnt + 1'b1;
            rst_req  <= 1'b1;
            st       <= S_RST1;
          end
        end
        S_RST1: if (rst_done) begin
          if (!presence) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else begin
            xfer_tx  <= CMD_BYTE;
            xfer_req <= 1'b1;
            st       <= S_CMD;
          end
        end
        S_CMD: begin
          if (xfer_timeout) begin
            done    <= 1'b1;
            aborted <= 1'b1;
            st      <= S_IDLE;
          end else if (xfer_done) begin
            acc_en   <= 1'b1;
            nib      <= '0;
            xfer_tx  <= enc(path[3:0]);
            xfer_req <= 1'b1;
            st       <= S_EXCH;
          end
        end
        S_EXCH: begin
          if (xfer_timeout) begin
            done    <= 1'b1;
            aborted <= 1'b1;
            acc_en  <= 1'b0;
            st      <= S_IDLE;
          end else if (xfer_done) begin
            idw[{nib, 2'b00} +: 4] <= rx_id;
            dsc[{nib, 2'b00} +: 4] <= rx_ds;
            if (nib == NW'(NIBS - 1)) begin
              acc_en  <= 1'b0;
              rst_req <= 1'b1;
              st      <= S_RST2;
            end else begin
              nib      <= nib_nx;
              xfer_tx  <= enc(path[{nib_nx, 2'b00} +: 4]);
              xfer_req <= 1'b1;
            end
          end
        end
        S_RST2: if (rst_done) st <= S_EVAL;
        S_EVAL: begin
          if (bus_err) begin
            st <= S_PASS;
          end else begin
            rom_id    <= idw;
            rom_valid <= 1'b1;
            dev_count <= dev_count + 1'b1;
            if (d_left == '0) begin
              done <= 1'b1;
              st   <= S_IDLE;
            end else begin
              path <= nxt;
              st   <= S_PASS;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/onew_search_chk.sv
module onew_search_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             aborted,
  input logic             rom_valid,
  input logic [CNT_W-1:0] dev_count,
  input logic             rst_req,
  input logic             acc_en,
  input logic             xfer_req,
  input logic [7:0]       xfer_tx
);
  p_one_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rst_req, xfer_req}));
  p_tx_even_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && acc_en) |-> ((xfer_tx & 8'h55) == 8'h00));
  p_no_reset_in_accel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en |-> !rst_req);
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rom_valid |=> !rom_valid);
  p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rom_valid |-> (dev_count == CNT_W'($past(dev_count) + 1'b1)));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_abort_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && aborted) |-> !acc_en);
  p_idle_at_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind onew_search onew_search_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .aborted(aborted),
  .rom_valid(rom_valid), .dev_count(dev_count), .rst_req(rst_req),
  .acc_en(acc_en), .xfer_req(xfer_req), .xfer_tx(xfer_tx)
);

// File: tb/sim_onew_search.sv
module sim_onew_search;
  localparam int CNT_W = 8;
  localparam int MAXD  = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic busy, done, aborted, rom_valid, rst_req, acc_en, xfer_req;
  logic [63:0] rom_id;
  logic [CNT_W-1:0] dev_count;
  logic [7:0] xfer_tx, xfer_rx = 8'h00;
  logic rst_done = 1'b0, presence = 1'b0, xfer_done = 1'b0, xfer_timeout = 1'b0;

  always #10 clk = ~clk;

  onew_search #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .aborted(aborted), .rom_id(rom_id), .rom_valid(rom_valid),
    .dev_count(dev_count), .rst_req(rst_req), .rst_done(rst_done),
    .presence(presence), .acc_en(acc_en), .xfer_req(xfer_req),
    .xfer_tx(xfer_tx), .xfer_done(xfer_done), .xfer_timeout(xfer_timeout),
    .xfer_rx(xfer_rx)
  );

  int total = 0, bad = 0;
  logic [63:0] devs [MAXD];
  logic [MAXD-1:0] act, seen;
  int ndev, err_mode, err_pass, to_at;
  int nres, npass, nxfer, bcnt, found, ndone;
  logic in_pass, exp_final, pend_ok, last_abort, last_with_valid;
  logic [63:0] exp_path, b_id, b_ds, pend_id;

  task automatic chk(input logic ok, input string tag, input logic [63:0] act_v, input logic [63:0] exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act_v, exp_v);
    end
  endtask

  function automatic logic [64:0] bnext(input logic [63:0] p, input logic [63:0] d);
    logic [63:0] dd, r;
    dd = d & ~p;
    for (int k = 63; k >= 0; k--) begin
      if (dd[k]) begin
        r = p;
        for (int j = k + 1; j < 64; j++) r[j] = 1'b0;
        r[k] = 1'b1;
        return {1'b0, r};
      end
    end
    return {1'b1, p};
  endfunction

  task automatic monitor();
    if (rom_valid) begin
      int hit;
      hit = -1;
      for (int i = 0; i < ndev; i++) if (devs[i] == rom_id) hit = i;
      chk(pend_ok, "R6 report only after good pass", {63'd0, rom_valid}, {63'd0, pend_ok});
      chk(rom_id == pend_id, "R4 rom_id from decoded replies", rom_id, pend_id);
      chk(hit >= 0 && !seen[hit >= 0 ? hit : 0], "R8 rom_id is a new device", rom_id, 64'(hit));
      if (hit >= 0) seen[hit] = 1'b1;
      found++;
      chk(dev_count == CNT_W'(found), "R8 dev_count steps", 64'(dev_count), 64'(found));
      chk(done == exp_final, "R9 done with final report", {63'd0, done}, {63'd0, exp_final});
      pend_ok = 1'b0;
    end
    if (done) begin
      ndone++;
      last_abort = aborted;
      last_with_valid = rom_valid;
    end
  endtask

  task automatic tick();
    @(negedge clk);
    monitor();
  endtask

  initial begin : responder
    int lat, n;
    logic [63:0] nr;
    logic [7:0] rx;
    logic h0, h1, r, ch, ib, db;
    forever begin
      tick();
      rst_done = 1'b0; xfer_done = 1'b0; xfer_timeout = 1'b0;
      if (rst_req) begin
        nres++;
        chk(!acc_en, "R5 accel off at reset", {63'd0, acc_en}, 64'd0);
        if (in_pass && bcnt == 17) begin
          in_pass = 1'b0;
          if (b_id[63] && b_ds[63]) begin
            pend_ok = 1'b0;
          end else begin
            pend_ok = 1'b1;
            pend_id = b_id;
            nr = bnext(exp_path, b_ds)[63:0];
            exp_final = bnext(exp_path, b_ds)[64];
            exp_path = nr;
          end
        end else begin
          in_pass = 1'b1;
          npass++;
          bcnt = 0;
          act = '0;
          for (int i = 0; i < ndev; i++) act[i] = 1'b1;
          b_id = '0; b_ds = '0;
        end
        lat = $urandom_range(1, 3);
        repeat (lat) tick();
        presence = (ndev > 0);
        rst_done = 1'b1;
      end else if (xfer_req) begin
        rx = 8'hFF;
        if (bcnt == 0) begin
          chk(xfer_tx == 8'hF0 && !acc_en, "R2 command byte with accel off", {55'd0, acc_en, xfer_tx}, 64'hF0);
        end else begin
          n = bcnt - 1;
          chk(acc_en, "R2 accel on during path bytes", {63'd0, acc_en}, 64'd1);
          chk((xfer_tx & 8'h55) == 8'h00 &&
              {xfer_tx[7], xfer_tx[5], xfer_tx[3], xfer_tx[1]} == exp_path[4*n +: 4],
              "R3 R7 path nibble", {56'd0, xfer_tx}, {60'd0, exp_path[4*n +: 4]});
          for (int j = 0; j < 4; j++) begin
            h0 = 1'b0; h1 = 1'b0;
            for (int i = 0; i < ndev; i++)
              if (act[i]) begin
                if (devs[i][4*n+j]) h1 = 1'b1; else h0 = 1'b1;
              end
            r = xfer_tx[2*j+1];
            if (h0 && h1) begin ib = r; db = 1'b1; ch = r; end
            else if (h1) begin ib = 1'b1; db = 1'b0; ch = 1'b1; end
            else if (h0) begin ib = 1'b0; db = 1'b0; ch = 1'b0; end
            else begin ib = 1'b1; db = 1'b1; ch = 1'b1; end
            for (int i = 0; i < ndev; i++) if (devs[i][4*n+j] != ch) act[i] = 1'b0;
            rx[2*j+1] = ib;
            rx[2*j] = db;
          end
          if (n == 15 && (err_mode == 2 || (err_mode == 1 && npass == err_pass))) rx[7:6] = 2'b11;
          for (int j = 0; j < 4; j++) begin
            b_id[4*n+j] = rx[2*j+1];
            b_ds[4*n+j] = rx[2*j];
          end
        end
        bcnt++;
        lat = $urandom_range(1, 3);
        repeat (lat) tick();
        xfer_rx = rx;
        if (nxfer == to_at) xfer_timeout = 1'b1; else xfer_done = 1'b1;
        nxfer++;
      end
    end
  end

  task automatic run_case(input int nd, input int em, input int ep, input int ta, input logic poke);
    int cyc;
    ndev = nd; err_mode = em; err_pass = ep; to_at = ta;
    nres = 0; npass = 0; nxfer = 0; bcnt = 0; found = 0; ndone = 0;
    in_pass = 1'b0; exp_final = 1'b0; pend_ok = 1'b0; exp_path = '0;
    seen = '0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (ndone == 0 && cyc < 30000) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 40) start = 1'b1;
      if (poke && cyc == 41) start = 1'b0;
    end
    repeat (20) @(negedge clk);
    chk(ndone == 1, "R9 single done", 64'(ndone), 64'd1);
    chk(!busy && !acc_en, "R11 idle after end", {62'd0, busy, acc_en}, 64'd0);
    if (ta >= 0) begin
      chk(last_abort, "R11 timeout aborts", {63'd0, last_abort}, 64'd1);
      chk(nxfer == ta + 1, "R11 no request after timeout", 64'(nxfer), 64'(ta + 1));
    end else if (em == 2 && nd > 0) begin
      chk(last_abort, "R10 pass limit aborts", {63'd0, last_abort}, 64'd1);
      chk(nres == 200 && npass == 100, "R10 R6 pass count at limit", 64'(nres), 64'd200);
      chk(found == 0, "R6 no report on bus error", 64'(found), 64'd0);
    end else if (nd == 0) begin
      chk(!last_abort && nres == 1 && nxfer == 0, "R1 no presence ends search", 64'(nres), 64'd1);
      chk(dev_count == 0, "R1 count zero", 64'(dev_count), 64'd0);
    end else begin
      chk(!last_abort && last_with_valid, "R9 normal end with report", {62'd0, last_abort, last_with_valid}, 64'd1);
      chk(found == nd && dev_count == CNT_W'(nd), "R8 all devices found", 64'(found), 64'(nd));
      chk(npass == nd + (em == 1 ? 1 : 0), "R6 R7 pass count", 64'(npass), 64'(nd + (em == 1 ? 1 : 0)));
      chk(nres == 2 * npass, "R5 two resets per pass", 64'(nres), 64'(2 * npass));
    end
  endtask

  task automatic rand_devs(input int nd);
    logic ok;
    for (int i = 0; i < nd; i++) begin
      ok = 1'b0;
      while (!ok) begin
        devs[i] = {1'b0, 31'($urandom), 32'($urandom)};
        ok = 1'b1;
        for (int k = 0; k < i; k++) if (devs[k] == devs[i]) ok = 1'b0;
      end
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !rom_valid && !rst_req && !xfer_req && !acc_en && dev_count == 0,
        "R12 reset state", {58'd0, busy, done, rom_valid, rst_req, xfer_req, acc_en}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_case(0, 0, 0, -1, 1'b0);
    devs[0] = 64'h0123_4567_89AB_CDE0;
    run_case(1, 0, 0, -1, 1'b0);
    devs[0] = 64'h3000_0000_0000_0000; devs[1] = 64'h3000_0000_0000_0001;
    devs[2] = 64'h7000_0000_0000_0000; devs[3] = 64'h3000_0000_4000_0000;
    run_case(4, 0, 0, -1, 1'b0);
    run_case(4, 1, 2, -1, 1'b0);
    for (int t = 0; t < 6; t++) begin
      int nd;
      nd = $urandom_range(2, MAXD);
      rand_devs(nd);
      run_case(nd, 0, 0, -1, t == 2);
    end
    rand_devs(3);
    run_case(3, 1, 1, -1, 1'b0);
    run_case(3, 2, 0, -1, 1'b0);
    run_case(3, 0, 0, 0, 1'b0);
    run_case(3, 0, 0, 9, 1'b0);
    run_case(3, 0, 0, 30, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule